// File: doc/BRIEF.md
# Multiplexed BCD Switch Scanner

This block reads one or two banks of four-digit BCD thumbwheel switches that share a single row of four digit-select strobes. While `enable` is high it raises the strobes one at a time. It waits a programmable number of cycles for the switch contacts and wiring to settle. It then samples four data lines per bank for the selected digit.

When all four digits have been captured, the block replaces the output words together, one 16-bit BCD word per bank, and signals completion. Scanning repeats back to back while `enable` stays high. Dropping `enable` throws away a partly finished scan, and the next scan starts again from the first digit.

The data lines are asynchronous to the clock and pass through a two-stage synchronizer before they are sampled. The block does not check that digits are valid BCD, and it does not convert them to binary.

Top module: `bcd_switch_scanner`

## Requirements
- R1: With NUM_BANKS banks, data lines `sw_data[4b+3:4b]` belong to bank b. Bank b's word appears on `result[16b+15:16b]`, a separate word for each bank.
- R2: At most one of the four strobe outputs is high in any cycle, and it is active high. The strobe count is four whatever NUM_BANKS is.
- R3: In the cycle after `enable` is sampled low, all strobes are low.
- R4: The first cycle after `enable` is sampled high shows `strobe` = 4'b0001. Each strobe stays high for a slot of `settle_cycles`+1 cycles, in the order bit 0, 1, 2, 3. Strobe bit 0 returns immediately after bit 3 while enabled.
- R5: Each digit is sampled in the last cycle of its slot, from the synchronized data. The digit read under strobe bit k lands in bits 4k+3:4k of the bank's word, so bit 0 gives the least significant digit. A correct read needs `settle_cycles` of at least 2.
- R6: The result words change only at scan completion, all banks in the same cycle, and stay stable otherwise.
- R7: `scan_done` is a one-cycle pulse. It is high in the first cycle the new words are visible, which is 4*(`settle_cycles`+1) cycles after strobe bit 0 first rises.
- R8: `done_sticky` is set by every completion and cleared by `status_clr`. If both happen in the same cycle, the completion wins.
- R9: If `enable` falls during a scan, no completion occurs and the results keep their old value. The next enable starts a full scan at strobe bit 0.
- R10: Reset clears the strobes, the results, `scan_done` and `done_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run scanning while high |
| settle_cycles | input | SETTLE_W | Cycles from strobe rise to sampling |
| status_clr | input | 1 | Clears the sticky completion bit |
| sw_data | input | 4*NUM_BANKS | Switch data lines, four per bank |
| strobe | output | 4 | Digit-select strobes, one-hot, active high |
| result | output | 16*NUM_BANKS | BCD words, one per bank |
| scan_done | output | 1 | One-cycle completion pulse |
| done_sticky | output | 1 | Sticky completion status |

## Verification
The bench builds the block with NUM_BANKS=2 and SETTLE_W=8. With two banks, the bench can check that bank words are kept apart and that both words are committed in the same cycle. With an 8-bit settle field, it can run slot lengths of 3 and 6 cycles, so strobe timing and completion latency are checked at two settle values. A bench switch model answers each strobe with that digit's value, so a digit placed in the wrong position, or read before the synchronizer has caught up, shows up as a wrong word.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  localparam int DIGITS  = 4;
  localparam int DIGIT_W = 4;
  localparam int WORD_W  = DIGITS * DIGIT_W;
  typedef logic [1:0] digit_idx_t;
endpackage

// File: rtl/bcd_scan_sync.sv
module bcd_scan_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/bcd_scan_seq.sv
module bcd_scan_seq
  import bcd_scan_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [DIGITS-1:0]   strobe,
  output digit_idx_t          digit_idx,
  output logic                sample,
  output logic                last
);
  logic                run_q, run_d;
  digit_idx_t          idx_q, idx_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;

  // sample in the final cycle of a slot; gated by enable so an abort drops it
  assign sample = run_q && enable && (cnt_q == settle_cycles);
  assign last   = sample && (idx_q == digit_idx_t'(DIGITS - 1));

  always_comb begin
    run_d = run_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (!enable) begin
      run_d = 1'b0;
      idx_d = '0;
      cnt_d = '0;
    end else if (!run_q) begin
      run_d = 1'b1;
      idx_d = '0;
      cnt_d = '0;
    end else if (sample) begin
      idx_d = idx_q + 2'd1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign strobe    = run_q ? (DIGITS'(1) << idx_q) : '0;
  assign digit_idx = idx_q;
endmodule

// File: rtl/bcd_scan_capture.sv
module bcd_scan_capture
  import bcd_scan_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sample,
  input  logic                          last,
  input  digit_idx_t                    digit_idx,
  input  logic [DIGIT_W*NUM_BANKS-1:0]  data,
  output logic [WORD_W*NUM_BANKS-1:0]   result,
  output logic                          commit_pulse
);
  localparam int SHADOW_W = WORD_W - DIGIT_W;

  logic commit_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SHADOW_W-1:0] shadow_q, shadow_d;
    logic [WORD_W-1:0]   word_q;
    logic [DIGIT_W-1:0]  nib;

    assign nib = data[b*DIGIT_W +: DIGIT_W];

    always_comb begin
      shadow_d = shadow_q;
      case (digit_idx)
        2'd0:    shadow_d[3:0]  = nib;
        2'd1:    shadow_d[7:4]  = nib;
        2'd2:    shadow_d[11:8] = nib;
        default: shadow_d       = shadow_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        word_q   <= '0;
      end else begin
        if (sample && !last) shadow_q <= shadow_d;
        if (last)            word_q   <= {nib, shadow_q};
      end
    end

    assign result[b*WORD_W +: WORD_W] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_q <= 1'b0;
    else        commit_q <= last;
  end

  assign commit_pulse = commit_q;
endmodule

// File: rtl/bcd_switch_scanner.sv
module bcd_switch_scanner
  import bcd_scan_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int SETTLE_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic [SETTLE_W-1:0]          settle_cycles,
  input  logic                         status_clr,
  input  logic [DIGIT_W*NUM_BANKS-1:0] sw_data,
  output logic [DIGITS-1:0]            strobe,
  output logic [WORD_W*NUM_BANKS-1:0]  result,
  output logic                         scan_done,
  output logic                         done_sticky
);
  localparam int DATA_W = DIGIT_W * NUM_BANKS;

  logic [DATA_W-1:0] data_sync;
  digit_idx_t        digit_idx;
  logic              sample, last;
  logic              sticky_q, sticky_d;

  bcd_scan_sync #(.W(DATA_W)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(sw_data), .q(data_sync)
  );

  bcd_scan_seq #(.SETTLE_W(SETTLE_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .settle_cycles(settle_cycles),
    .strobe(strobe), .digit_idx(digit_idx), .sample(sample), .last(last)
  );

  bcd_scan_capture #(.NUM_BANKS(NUM_BANKS)) cap_i (
    .clk(clk), .rst_n(rst_n), .sample(sample), .last(last),
    .digit_idx(digit_idx), .data(data_sync), .result(result),
    .commit_pulse(scan_done)
  );

  always_comb begin
    sticky_d = sticky_q;
    if (last)            sticky_d = 1'b1;
    else if (status_clr) sticky_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign done_sticky = sticky_q;
endmodule

// File: rtl/bcd_switch_scanner_chk.sv
module bcd_switch_scanner_chk #(
  parameter int NUM_BANKS = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic                    status_clr,
  input logic [3:0]              strobe,
  input logic [16*NUM_BANKS-1:0] result,
  input logic                    scan_done,
  input logic                    done_sticky
);
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  p_strobe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (strobe == 4'b0000));

  p_strobe_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != 4'b0000) |=> (strobe == 4'b0000 || strobe == $past(strobe) ||
                             strobe == {$past(strobe[2:0]), $past(strobe[3])}));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |-> $stable(result));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> done_sticky);

  p_sticky_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |=> (!done_sticky || scan_done));
endmodule

bind bcd_switch_scanner bcd_switch_scanner_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .status_clr(status_clr),
  .strobe(strobe), .result(result), .scan_done(scan_done),
  .done_sticky(done_sticky)
);

// File: tb/bcd_switch_scanner_tb_top.sv
module bcd_switch_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic [SW-1:0] settle_cycles;
  logic          status_clr;
  logic [4*NB-1:0]  sw_data;
  logic [3:0]       strobe;
  logic [16*NB-1:0] result;
  logic             scan_done;
  logic             done_sticky;

  logic [3:0] sw_val [NB][4];
  logic [31:0] exp_q[$];
  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_switch_scanner #(.NUM_BANKS(NB), .SETTLE_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .settle_cycles(settle_cycles),
    .status_clr(status_clr), .sw_data(sw_data), .strobe(strobe),
    .result(result), .scan_done(scan_done), .done_sticky(done_sticky)
  );

  // switch model: the strobed digit drives the bank's data lines
  always_comb begin
    sw_data = '0;
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 4; k++)
        if (strobe[k]) sw_data[b*4 +: 4] = sw_val[b][k];
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of();
    logic [31:0] w = '0;
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 4; k++)
        w[b*16 + k*4 +: 4] = sw_val[b][k];
    return w;
  endfunction

  task automatic set_vals(logic [15:0] b0, logic [15:0] b1);
    for (int k = 0; k < 4; k++) begin
      sw_val[0][k] = b0[k*4 +: 4];
      sw_val[1][k] = b1[k*4 +: 4];
    end
  endtask

  // monitor: pops the expected word at each completion pulse (R1, R5)
  always @(negedge clk) begin
    if (rst_n && scan_done) begin
      if (exp_q.size() == 0) check("R6 unexpected completion", 32'd1, 32'd0);
      else check("R1/R5 result words", result, exp_q.pop_front());
    end
  end

  // driver: one timed scan, stimulus is already set, enable is low on entry
  task automatic timed_scan(int s, logic [31:0] prev);
    int slot = s + 1;
    settle_cycles = SW'(s);
    exp_q.push_back(word_of());
    @(negedge clk) enable = 1'b1;
    for (int j = 0; j < 4*slot; j++) begin
      @(negedge clk);
      check("R4 strobe sequence", {28'd0, strobe}, 32'd1 << (j / slot));
      if (j == 4*slot - 1) begin
        check("R7 no early done", {31'd0, scan_done}, 32'd0);
        check("R6 result held before commit", result, prev);
      end
    end
    @(negedge clk);
    check("R7 done latency", {31'd0, scan_done}, 32'd1);
    check("R4 strobe wraps to bit 0", {28'd0, strobe}, 32'd1);
    check("R8 sticky set", {31'd0, done_sticky}, 32'd1);
  endtask

  task automatic disable_and_check();
    enable = 1'b0;
    @(negedge clk);
    check("R3 strobes low when disabled", {28'd0, strobe}, 32'd0);
  endtask

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; enable = 1'b0; status_clr = 1'b0; settle_cycles = SW'(2);
    set_vals(16'h0000, 16'h0000);
    repeat (3) @(negedge clk);
    check("R10 reset strobe", {28'd0, strobe}, 32'd0);
    check("R10 reset result", result, 32'd0);
    check("R10 reset done", {31'd0, scan_done}, 32'd0);
    check("R10 reset sticky", {31'd0, done_sticky}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // settle 2, distinct digits per bank
    set_vals(16'h4321, 16'h5089);
    timed_scan(2, 32'd0);
    // keep running: two more back-to-back scans (R4)
    exp_q.push_back(word_of());
    exp_q.push_back(word_of());
    while (exp_q.size() != 0) @(negedge clk);
    disable_and_check();
    check("R6 result held after disable", result, 32'h5089_4321);

    // sticky clear (R8)
    status_clr = 1'b1;
    @(negedge clk) status_clr = 1'b0;
    check("R8 sticky cleared", {31'd0, done_sticky}, 32'd0);

    // settle 5, new pattern
    set_vals(16'h7406, 16'h1293);
    timed_scan(5, 32'h5089_4321);
    @(negedge clk);
    disable_and_check();

    // abort mid-scan (R9)
    held = result;
    set_vals(16'h1111, 16'h2222);
    settle_cycles = SW'(5);
    @(negedge clk) enable = 1'b1;
    repeat (13) begin
      @(negedge clk);
      check("R9 no completion on aborted scan", {31'd0, scan_done}, 32'd0);
    end
    disable_and_check();
    check("R9 results keep old value", result, held);
    repeat (3) @(negedge clk);
    check("R9 no late completion", {31'd0, scan_done}, 32'd0);

    // restart after abort: full scan from bit 0, boundary digits
    set_vals(16'h9999, 16'h9090);
    timed_scan(3, held);
    @(negedge clk);
    disable_and_check();
    check("R1 bank words", result, 32'h9090_9999);

    repeat (5) @(negedge clk);
    check("R6 queue drained", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule